// File: doc/BRIEF.md
# Serial Display Transmitter Control Registers

This block is the software-visible register bank that sits beside a multi-lane high-speed serial video transmitter. A processor reaches it over a plain synchronous register bus: an address, a write strobe, write data, and read data that is returned combinationally in the same cycle. Writes are captured on the next rising clock edge.

On the status side it reports the transmit datapath's pixel FIFO full and empty levels and its initialization-done flag live. It latches an unsupported-video-type event into a sticky bit, which software clears by writing a 1 to it. It also shows per-lane stop-state and active-low ultra-low-power indications, covering one clock lane and eight data lanes. On the control side it holds per-data-lane skew calibration requests and per-lane ultra-low-power entry requests, and drives them straight to the physical layer. A 5-bit enable mask selects which of the four status bits raise the single interrupt line.

Top module: `sdt_csr_bank`

## Requirements
- R1: After a synchronous active-low reset, the enable mask, the sticky event bit, every skew request and every low-power entry request are 0, and `irq_o` is 0.
- R2: A read of offset 0x00 returns live status in the same cycle: bit 0 is `fifo_full_i`, bit 1 is `fifo_empty_i`, and bit 3 is `init_done_i`. Bits 31:4 read 0.
- R3: Status bit 2 sets on the clock edge after `bad_dtype_i` is high and then holds. A write to 0x00 with data bit 2 = 1 clears it, while data bit 2 = 0 leaves it unchanged.
- R4: When a clearing write and a `bad_dtype_i` event fall in the same cycle, bit 2 ends up set.
- R5: Offset 0x04 is a read/write 5-bit enable mask. Bits 31:5 of the write are dropped and read back as 0.
- R6: `irq_o` is high exactly when some status bit n (n = 0..3) and enable bit n are both 1. It follows the live status bits within the same cycle. Enable bit 4 has no effect on `irq_o`.
- R7: Offset 0x08 reads `lane_stop_i` in bits 7:0, one bit per data lane 0..7.
- R8: Offset 0x0C reads `lane_lp_n_i` in bits 8:0. Bit 0 is the clock lane and bit k+1 is data lane k. A 0 means that lane is in the ultra-low-power state.
- R9: Offset 0x10 is an 8-bit read/write register. Bit k drives `skew_req_o[k]` from the edge that captures the write, and the output holds until the next write to 0x10.
- R10: Offset 0x18 is a 9-bit read/write register. Bit 0 drives the clock-lane entry request and bit k+1 drives the request for data lane k, from the edge that captures the write. Each request holds until software rewrites it.
- R11: Reads of the reserved offset 0x14, or of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x18, return 0. Writes to them change no register.
- R12: Writes to the read-only offsets 0x08 and 0x0C, and to status bits 0, 1 and 3, change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fifo_full_i | input | 1 | Pixel FIFO full level |
| fifo_empty_i | input | 1 | Pixel FIFO empty level |
| bad_dtype_i | input | 1 | One-cycle unsupported video data type event |
| init_done_i | input | 1 | Initialization-done level |
| lane_stop_i | input | 8 | Per-data-lane stop-state indication |
| lane_lp_n_i | input | 9 | Active-low ultra-low-power indication, bit 0 for the clock lane |
| skew_req_o | output | 8 | Per-data-lane skew calibration request |
| lp_entry_o | output | 9 | Ultra-low-power entry request, bit 0 for the clock lane |
| irq_o | output | 1 | Masked interrupt |

## Verification
Read data and `irq_o` are combinational, so they are due in the same cycle as the address and the live status inputs. Register-backed results appear one edge later: the sticky bit, the enable mask, and the skew and entry outputs reflect a write or an event from the edge that captures it. The bench drives every input at the falling edge and checks one time unit later against a model. That model advances only after the following rising edge, so each check sees exactly the state that should be visible between edges.

// File: rtl/sdt_csr_pkg.sv
// Shared constants and types for the transmitter control register bank.
// Assumes byte offsets on the register bus; offsets are fixed by software.
package sdt_csr_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int N_LANES  = 8;
    localparam int STAT_W   = 4;
    localparam int EN_W     = 5;
    localparam int STICKY_B = 2;

    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EN    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STOP  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_LPST  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SKEW  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_ENTRY = 8'h18;

    typedef struct packed {
        logic stat;
        logic en;
        logic stop;
        logic lpst;
        logic skew;
        logic entry;
    } csr_sel_t;
endpackage

// File: rtl/sdt_csr_decode.sv
// Address decoder: turns a byte offset into a one-hot register select.
// Assumes exact offset match; any other offset selects nothing.
module sdt_csr_decode
    import sdt_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output csr_sel_t          sel
);
    // Compare the offset against each mapped register.
    always_comb begin
        sel       = '0;
        sel.stat  = (addr == OFS_STAT);
        sel.en    = (addr == OFS_EN);
        sel.stop  = (addr == OFS_STOP);
        sel.lpst  = (addr == OFS_LPST);
        sel.skew  = (addr == OFS_SKEW);
        sel.entry = (addr == OFS_ENTRY);
    end

    // At most one register is ever addressed; reserved offsets select none.
    p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/sdt_csr_irq_status.sv
// Interrupt status and enable: live status bits, one sticky event bit
// cleared by writing 1, an enable mask and the masked interrupt output.
// Assumes the event input is already synchronous to clk.
module sdt_csr_irq_status
    import sdt_csr_pkg::*;
#(
    parameter int MASK_W = EN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_en,
    input  logic [MASK_W-1:0] wdata,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic              bad_dtype,
    input  logic              init_done,
    output logic [STAT_W-1:0] stat_o,
    output logic [MASK_W-1:0] en_o,
    output logic              irq_o
);
    logic sticky_q;
    logic clr_req;

    assign clr_req = wr_stat && wdata[STICKY_B];

    // Sticky event bit: a new event takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         sticky_q <= 1'b0;
        else if (bad_dtype) sticky_q <= 1'b1;
        else if (clr_req)   sticky_q <= 1'b0;
    end

    // Enable mask register, all bits stored.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_o <= '0;
        else if (wr_en) en_o <= wdata;
    end

    // Assemble the visible status word from live inputs and the sticky bit.
    always_comb begin
        stat_o    = {init_done, sticky_q, fifo_empty, fifo_full};
    end

    // Interrupt: any status bit whose enable is set.
    always_comb begin
        irq_o = |(stat_o & en_o[STAT_W-1:0]);
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_dtype |=> stat_o[STICKY_B]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !bad_dtype) |=> !stat_o[STICKY_B]);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && !bad_dtype) |=> $stable(stat_o[STICKY_B]));
    p_no_irq_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o[STAT_W-1:0] == '0) |-> !irq_o);
endmodule

// File: rtl/sdt_csr_req_reg.sv
// Request register: a software-written bit vector driven straight to the PHY.
// One flop per lane; each bit only changes on a write to this register.
module sdt_csr_req_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] req_o
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        // Per-lane request flop, loaded on a write.
        always_ff @(posedge clk) begin
            if (!rst_n)  req_o[i] <= 1'b0;
            else if (wr) req_o[i] <= wdata[i];
        end
    end

    p_follow_r9_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (req_o == $past(wdata)));
    p_hold_r9_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(req_o));
endmodule

// File: rtl/sdt_csr_readmux.sv
// Read multiplexer: zero-extends the selected register onto the read bus.
// Returns zero when no register is selected.
module sdt_csr_readmux
    import sdt_csr_pkg::*;
#(
    parameter int LANES = N_LANES,
    parameter int MASK_W = EN_W
) (
    input  csr_sel_t            sel,
    input  logic [STAT_W-1:0]   stat,
    input  logic [MASK_W-1:0]   en,
    input  logic [LANES-1:0]    stop,
    input  logic [LANES:0]      lpst,
    input  logic [LANES-1:0]    skew,
    input  logic [LANES:0]      entry,
    output logic [DATA_W-1:0]   rdata
);
    // OR together the gated, zero-extended registers.
    always_comb begin
        rdata = '0;
        if (sel.stat)  rdata = rdata | DATA_W'(stat);
        if (sel.en)    rdata = rdata | DATA_W'(en);
        if (sel.stop)  rdata = rdata | DATA_W'(stop);
        if (sel.lpst)  rdata = rdata | DATA_W'(lpst);
        if (sel.skew)  rdata = rdata | DATA_W'(skew);
        if (sel.entry) rdata = rdata | DATA_W'(entry);
    end
endmodule

// File: rtl/sdt_csr_bank.sv
// Top of the transmitter control register bank: decoder, status/interrupt
// unit, skew and low-power entry request registers, and the read mux.
// Assumes all inputs are synchronous to clk; reads are combinational.
module sdt_csr_bank
    import sdt_csr_pkg::*;
#(
    parameter int LANES = N_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fifo_full_i,
    input  logic              fifo_empty_i,
    input  logic              bad_dtype_i,
    input  logic              init_done_i,
    input  logic [LANES-1:0]  lane_stop_i,
    input  logic [LANES:0]    lane_lp_n_i,
    output logic [LANES-1:0]  skew_req_o,
    output logic [LANES:0]    lp_entry_o,
    output logic              irq_o
);
    localparam int ENTRY_W = LANES + 1;
    localparam int USED_W  = (ENTRY_W > EN_W) ? ENTRY_W : EN_W;

    csr_sel_t            sel;
    logic [STAT_W-1:0]   stat;
    logic [EN_W-1:0]     en;
    logic                wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:USED_W];

    sdt_csr_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .sel   (sel)
    );

    sdt_csr_irq_status #(.MASK_W(EN_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stat    (bus_wr && sel.stat),
        .wr_en      (bus_wr && sel.en),
        .wdata      (bus_wdata[EN_W-1:0]),
        .fifo_full  (fifo_full_i),
        .fifo_empty (fifo_empty_i),
        .bad_dtype  (bad_dtype_i),
        .init_done  (init_done_i),
        .stat_o     (stat),
        .en_o       (en),
        .irq_o      (irq_o)
    );

    sdt_csr_req_reg #(.W(LANES)) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr && sel.skew),
        .wdata (bus_wdata[LANES-1:0]),
        .req_o (skew_req_o)
    );

    sdt_csr_req_reg #(.W(ENTRY_W)) u_entry (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr && sel.entry),
        .wdata (bus_wdata[ENTRY_W-1:0]),
        .req_o (lp_entry_o)
    );

    sdt_csr_readmux #(.LANES(LANES), .MASK_W(EN_W)) u_rmux (
        .sel   (sel),
        .stat  (stat),
        .en    (en),
        .stop  (lane_stop_i),
        .lpst  (lane_lp_n_i),
        .skew  (skew_req_o),
        .entry (lp_entry_o),
        .rdata (bus_rdata)
    );

    // Read-only and reserved offsets never disturb the request outputs.
    p_ro_no_effect_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sel.skew && !sel.entry) |=>
            ($stable(skew_req_o) && $stable(lp_entry_o)));
endmodule

// File: tb/tb_sdt_csr_bank.sv
module tb_sdt_csr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fifo_full_i = 0, fifo_empty_i = 0, bad_dtype_i = 0, init_done_i = 0;
    logic [7:0]  lane_stop_i = '0;
    logic [8:0]  lane_lp_n_i = '1;
    logic [7:0]  skew_req_o;
    logic [8:0]  lp_entry_o;
    logic        irq_o;

    int total = 0;
    int fails = 0;

    logic [4:0] m_en = '0;
    logic       m_sticky = 1'b0;
    logic [7:0] m_skew = '0;
    logic [8:0] m_entry = '0;

    always #2 clk = ~clk;

    sdt_csr_bank dut (.*);

    function automatic logic [3:0] m_stat();
        return {init_done_i, m_sticky, fifo_empty_i, fifo_full_i};
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h00: return {28'b0, m_stat()};
            8'h04: return {27'b0, m_en};
            8'h08: return {24'b0, lane_stop_i};
            8'h0C: return {23'b0, lane_lp_n_i};
            8'h10: return {24'b0, m_skew};
            8'h18: return {23'b0, m_entry};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h04: return "R5";
            8'h08: return "R7";
            8'h0C: return "R8";
            8'h10: return "R9";
            8'h18: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Check every output against the model, then advance one clock.
    task automatic cycle(string tag);
        #1;
        chk(tag != "" ? tag : req_of(bus_addr), bus_rdata, exp_read(bus_addr));
        chk(tag != "" ? tag : "R6", {31'b0, irq_o}, {31'b0, |(m_stat() & m_en[3:0])});
        chk(tag != "" ? tag : "R9", {24'b0, skew_req_o}, {24'b0, m_skew});
        chk(tag != "" ? tag : "R10", {23'b0, lp_entry_o}, {23'b0, m_entry});
        @(posedge clk);
        if (rst_n && bus_wr) begin
            case (bus_addr)
                8'h00: if (bus_wdata[2]) m_sticky = 1'b0;
                8'h04: m_en = bus_wdata[4:0];
                8'h10: m_skew = bus_wdata[7:0];
                8'h18: m_entry = bus_wdata[8:0];
                default: ;
            endcase
        end
        if (rst_n && bad_dtype_i) m_sticky = 1'b1;
        @(negedge clk);
    endtask

    task automatic acc(logic [7:0] a, logic w, logic [31:0] d, string tag);
        bus_addr = a; bus_wr = w; bus_wdata = d;
        cycle(tag);
    endtask

    initial begin
        #800000;
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = '1; bad_dtype_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bad_dtype_i = 1'b0;
        rst_n = 1'b1;
        acc(8'h00, 0, 0, "R1");
        acc(8'h04, 0, 0, "R1");
        acc(8'h18, 0, 0, "R1");
        // R2: live status
        fifo_full_i = 1; init_done_i = 1;
        acc(8'h00, 0, 0, "R2");
        fifo_full_i = 0; fifo_empty_i = 1;
        acc(8'h00, 0, 0, "R2");
        // R5: enable width
        acc(8'h04, 1, 32'hFFFF_FFFF, "R5");
        acc(8'h04, 0, 0, "R5");
        // R6: enable bit 4 alone raises nothing
        acc(8'h04, 1, 32'h10, "R6");
        fifo_full_i = 1; fifo_empty_i = 1; init_done_i = 1;
        acc(8'h00, 0, 0, "R6");
        // R3: sticky set, hold on write 0, clear on write 1
        bad_dtype_i = 1;
        acc(8'h00, 0, 0, "R3");
        bad_dtype_i = 0;
        acc(8'h00, 1, 32'hFFFF_FFFB, "R3");
        acc(8'h00, 0, 0, "R3");
        acc(8'h00, 1, 32'h4, "R3");
        acc(8'h00, 0, 0, "R3");
        // R4: set wins over simultaneous clear
        bad_dtype_i = 1;
        acc(8'h00, 1, 32'h4, "R4");
        bad_dtype_i = 0;
        acc(8'h00, 0, 0, "R4");
        acc(8'h04, 1, 32'h4, "R6");
        acc(8'h00, 0, 0, "R6");
        // R9 and R10: request registers
        acc(8'h10, 1, 32'hA5, "R9");
        acc(8'h18, 1, 32'h1C3, "R10");
        acc(8'h10, 0, 0, "R9");
        // R11: reserved and unmapped offsets
        acc(8'h14, 1, 32'hFFFF_FFFF, "R11");
        acc(8'h14, 0, 0, "R11");
        acc(8'h11, 1, 32'hFFFF_FFFF, "R11");
        acc(8'h11, 0, 0, "R11");
        // R12: read-only offsets
        lane_stop_i = 8'h3C; lane_lp_n_i = 9'h0F0;
        acc(8'h08, 1, 32'hFFFF_FFFF, "R12");
        acc(8'h0C, 1, 32'h0, "R12");
        acc(8'h08, 0, 0, "R7");
        acc(8'h0C, 0, 0, "R8");
        acc(8'h18, 0, 0, "R12");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] pick;
            pick = 3'($urandom_range(0, 7));
            fifo_full_i  = 1'($urandom);
            fifo_empty_i = 1'($urandom);
            init_done_i  = 1'($urandom);
            bad_dtype_i  = ($urandom_range(0, 7) == 0);
            lane_stop_i  = 8'($urandom);
            lane_lp_n_i  = 9'($urandom);
            case (pick)
                3'd0: bus_addr = 8'h00;
                3'd1: bus_addr = 8'h04;
                3'd2: bus_addr = 8'h08;
                3'd3: bus_addr = 8'h0C;
                3'd4: bus_addr = 8'h10;
                3'd5: bus_addr = 8'h14;
                3'd6: bus_addr = 8'h18;
                default: bus_addr = 8'($urandom);
            endcase
            bus_wr = 1'($urandom);
            bus_wdata = $urandom;
            cycle("");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule